// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port memory and watches the chip-enable and address of each port, called left and right. When both ports are enabled and aim at the same location, it picks one port to proceed. The other port gets an active-low busy indication. The block also suppresses that port's write strobe internally, so the memory never sees a write from a port that lost the collision. Whether either access is a read or a write plays no part in who loses.

The circuit is synchronous. Each port's enable and address are registered on every clock. A match that first shows up in those registers is charged to the port whose request changed on that clock. If both changed on the same clock, the right port loses. A busy indication, once raised, holds until the match ends, either because the addresses part or because an enable drops.

A mode input lets several copies be cascaded to widen the data path. In master mode the block computes the busy signals and drives them. In slave mode the computed result is not driven. The busy outputs sit high, and a separate busy input per port acts only as a write inhibit for that port. This lets a slave follow the decision of a master.

Top module: `dp_collision_arb`

## Requirements
- R1: Both busy outputs (`l_busy_n`, `r_busy_n`) are high whenever the registered addresses differ or either registered enable is low. They are also high out of reset.
- R2: When a match forms, busy goes low on the port whose enable or address changed on the clock that formed it, and the port that was already settled keeps access. Busy appears on the second rising edge after the input change that creates the match, and not on the first.
- R3: If both ports change on the same clock and thereby form a match, the right port gets busy. The two busy outputs are never low together.
- R4: The write-request inputs have no influence on which port gets busy.
- R5: Busy stays low on the losing port while the match persists. It returns high on the second rising edge after the input change that ends the match, whether an address changed or an enable dropped.
- R6: In master mode (`master_mode`=1), each gated write output equals that port's write request AND its busy output. The `*_busy_in` pins have no effect in this mode.
- R7: In slave mode (`master_mode`=0), both busy outputs are held high whatever the addresses do. Each gated write output equals that port's write request AND that port's `*_busy_in` pin, so a low input blocks writes and a high input passes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_mode | input | 1 | 1 = compute and drive busy; 0 = busy pins act as write inhibits |
| l_en | input | 1 | Left port enable, active high |
| l_addr | input | AW | Left port address |
| l_wr_req | input | 1 | Left port raw write request |
| r_en | input | 1 | Right port enable, active high |
| r_addr | input | AW | Right port address |
| r_wr_req | input | 1 | Right port raw write request |
| l_busy_in | input | 1 | Left write-inhibit input (active low), used in slave mode |
| r_busy_in | input | 1 | Right write-inhibit input (active low), used in slave mode |
| l_busy_n | output | 1 | Left busy, active low |
| r_busy_n | output | 1 | Right busy, active low |
| l_wr_gated | output | 1 | Left write strobe after busy gating |
| r_wr_gated | output | 1 | Right write strobe after busy gating |

## Verification
The bench forms matches in every order: left settled first, right settled first, both arriving on one edge, and a loser that drops out and comes back so that it becomes the newcomer. A design that judged by match alone, or by a fixed side, would flag the wrong port in at least one of these orders. Matches at address zero and at the top address catch a comparator that drops a bit. Read/write mixes that must leave the outcome unchanged catch arbitration that leaks the write request into the decision. Checks one edge early and one edge late catch an off-by-one register stage in both setting and clearing. In slave mode, with a live collision present, the busy outputs must stay high while the inhibit pins alone gate writes. In master mode, those same pins held low must change nothing; a design that mixed the two sources would fail one of these checks.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    LOSE_NONE  = 2'd0,
    LOSE_LEFT  = 2'd1,
    LOSE_RIGHT = 2'd2
  } loser_e;

  // The port that moved on the forming clock is the newcomer and loses.
  // When both moved, the right side loses by fixed rule.
  function automatic loser_e pick_loser(input logic left_moved, input logic right_moved);
    if (right_moved)     return LOSE_RIGHT;
    else if (left_moved) return LOSE_LEFT;
    else                 return LOSE_RIGHT;
  endfunction

  function automatic logic busy_blocks(input logic req, input logic blocked);
    return req & ~blocked;
  endfunction

endpackage

// File: rtl/req_sampler.sv
module req_sampler #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic          en_q,
  output logic [AW-1:0] addr_q,
  output logic          moved
);
  logic          en_qq;
  logic [AW-1:0] addr_qq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      addr_q  <= '0;
      en_qq   <= 1'b0;
      addr_qq <= '0;
    end else begin
      en_q    <= en;
      addr_q  <= addr;
      en_qq   <= en_q;
      addr_qq <= addr_q;
    end
  end

  assign moved = (en_q != en_qq) || (addr_q != addr_qq);
endmodule

// File: rtl/loser_track.sv
module loser_track
  import arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hit,
  input  logic   l_moved,
  input  logic   r_moved,
  output loser_e loser
);
  loser_e loser_nx;

  always_comb begin
    if (!hit)                   loser_nx = LOSE_NONE;
    else if (loser == LOSE_NONE) loser_nx = pick_loser(l_moved, r_moved);
    else                        loser_nx = loser;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) loser <= LOSE_NONE;
    else        loser <= loser_nx;
  end
endmodule

// File: rtl/dp_collision_arb.sv
module dp_collision_arb
  import arb_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_mode,
  input  logic          l_en,
  input  logic [AW-1:0] l_addr,
  input  logic          l_wr_req,
  input  logic          r_en,
  input  logic [AW-1:0] r_addr,
  input  logic          r_wr_req,
  input  logic          l_busy_in,
  input  logic          r_busy_in,
  output logic          l_busy_n,
  output logic          r_busy_n,
  output logic          l_wr_gated,
  output logic          r_wr_gated
);
  localparam int NP = 2;

  logic [NP-1:0]         en_raw, en_q, moved, wr_req, blk_pin, blk_eff, wr_out;
  logic [NP-1:0][AW-1:0] addr_raw, addr_q;
  logic                  addr_hit, l_moved, r_moved;
  logic                  l_lost, r_lost;
  loser_e                loser;

  assign en_raw   = {r_en, l_en};
  assign addr_raw = {r_addr, l_addr};
  assign wr_req   = {r_wr_req, l_wr_req};
  assign blk_pin  = {~r_busy_in, ~l_busy_in};

  for (genvar p = 0; p < NP; p++) begin : g_port
    req_sampler #(.AW(AW)) u_smp (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en_raw[p]),
      .addr   (addr_raw[p]),
      .en_q   (en_q[p]),
      .addr_q (addr_q[p]),
      .moved  (moved[p])
    );
  end

  assign l_moved  = moved[0];
  assign r_moved  = moved[1];
  assign addr_hit = en_q[0] & en_q[1] & (addr_q[0] == addr_q[1]);

  loser_track u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (addr_hit),
    .l_moved (l_moved),
    .r_moved (r_moved),
    .loser   (loser)
  );

  assign l_lost = (loser == LOSE_LEFT);
  assign r_lost = (loser == LOSE_RIGHT);

  assign l_busy_n = ~(master_mode & l_lost);
  assign r_busy_n = ~(master_mode & r_lost);

  for (genvar p = 0; p < NP; p++) begin : g_gate
    assign blk_eff[p] = master_mode ? ((p == 0) ? l_lost : r_lost) : blk_pin[p];
    assign wr_out[p]  = busy_blocks(wr_req[p], blk_eff[p]);
  end

  assign l_wr_gated = wr_out[0];
  assign r_wr_gated = wr_out[1];
endmodule

// File: rtl/dp_collision_arb_chk.sv
module dp_collision_arb_chk (
  input logic clk,
  input logic rst_n,
  input logic master_mode,
  input logic l_wr_req,
  input logic r_wr_req,
  input logic l_busy_in,
  input logic r_busy_in,
  input logic l_busy_n,
  input logic r_busy_n,
  input logic l_wr_gated,
  input logic r_wr_gated,
  input logic addr_hit
);
  // R3
  never_both_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_busy_n || r_busy_n));

  // R1
  no_hit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |=> (l_busy_n && r_busy_n));

  // R5
  right_loser_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !r_busy_n && addr_hit) |=> (!r_busy_n || !master_mode));

  // R5
  left_loser_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !l_busy_n && addr_hit) |=> (!l_busy_n || !master_mode));

  // R6
  master_left_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode |-> (l_wr_gated == (l_wr_req && l_busy_n)));

  // R6
  master_right_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode |-> (r_wr_gated == (r_wr_req && r_busy_n)));

  // R7
  slave_outputs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (l_busy_n && r_busy_n));

  // R7
  slave_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> ((l_wr_gated == (l_wr_req && l_busy_in)) &&
                      (r_wr_gated == (r_wr_req && r_busy_in))));
endmodule

bind dp_collision_arb dp_collision_arb_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .master_mode (master_mode),
  .l_wr_req    (l_wr_req),
  .r_wr_req    (r_wr_req),
  .l_busy_in   (l_busy_in),
  .r_busy_in   (r_busy_in),
  .l_busy_n    (l_busy_n),
  .r_busy_n    (r_busy_n),
  .l_wr_gated  (l_wr_gated),
  .r_wr_gated  (r_wr_gated),
  .addr_hit    (addr_hit)
);

// File: tb/dp_collision_arb_tb.sv
module dp_collision_arb_tb;
  localparam int AW = 13;
  localparam logic [AW-1:0] TOP = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_mode = 1'b1;
  logic l_en = 1'b0, r_en = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_wr_req = 1'b0, r_wr_req = 1'b0;
  logic l_busy_in = 1'b1, r_busy_in = 1'b1;
  logic l_busy_n, r_busy_n, l_wr_gated, r_wr_gated;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string    tag;
    logic [3:0] exp;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  dp_collision_arb #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_en(l_en), .l_addr(l_addr), .l_wr_req(l_wr_req),
    .r_en(r_en), .r_addr(r_addr), .r_wr_req(r_wr_req),
    .l_busy_in(l_busy_in), .r_busy_in(r_busy_in),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
    .l_wr_gated(l_wr_gated), .r_wr_gated(r_wr_gated)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic drive(input logic le, input logic [AW-1:0] la,
                       input logic re, input logic [AW-1:0] ra);
    l_en = le; l_addr = la; r_en = re; r_addr = ra;
  endtask

  // Expected gated strobes are derived from the requirement text.
  task automatic expect_out(input string tag, input logic lb, input logic rb);
    item_t it;
    logic lblk, rblk;
    lblk = master_mode ? ~lb : ~l_busy_in;
    rblk = master_mode ? ~rb : ~r_busy_in;
    it.tag = tag;
    it.exp = {lb, rb, l_wr_req & ~lblk, r_wr_req & ~rblk};
    sb.push_back(it);
    #1;
  endtask

  initial begin : monitor
    item_t it;
    logic [3:0] act;
    forever begin
      wait (sb.size() != 0);
      it = sb.pop_front();
      act = {l_busy_n, r_busy_n, l_wr_gated, r_wr_gated};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: {lb,rb,lwg,rwg} actual %b expected %b", it.tag, act, it.exp);
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    step(2);
    rst_n = 1'b1;
    step(1);
    expect_out("R1 reset idle", 1, 1);

    // different addresses
    drive(1, 13'd5, 1, 13'd9); step(2);
    expect_out("R1 addresses differ", 1, 1);
    // same address, right disabled
    drive(1, 13'd5, 0, 13'd5); step(2);
    expect_out("R1 right enable low", 1, 1);

    // left settled, right arrives; writes requested on both
    l_wr_req = 1; r_wr_req = 1;
    drive(1, 13'd5, 1, 13'd5); step(1);
    expect_out("R2 not yet after one edge", 1, 1);
    step(1);
    expect_out("R2 newcomer right busy, R6 gating", 1, 0);
    step(3);
    expect_out("R5 busy held", 1, 0);
    l_busy_in = 0; r_busy_in = 0; #1;
    expect_out("R6 pins ignored in master", 1, 0);
    l_busy_in = 1; r_busy_in = 1;

    // address change ends the match
    drive(1, 13'd5, 1, 13'd6); step(1);
    expect_out("R5 still busy one edge later", 1, 0);
    step(1);
    expect_out("R5 clears on address change", 1, 1);

    // right settled first, left arrives
    drive(0, 13'd0, 0, 13'd0); step(2);
    drive(0, 13'd0, 1, 13'd7); step(2);
    drive(1, 13'd7, 1, 13'd7); step(2);
    expect_out("R2 newcomer left busy", 0, 1);
    // left drops enable, then returns
    drive(0, 13'd7, 1, 13'd7); step(2);
    expect_out("R5 clears on enable drop", 1, 1);
    drive(1, 13'd7, 1, 13'd7); step(2);
    expect_out("R2 returning left busy again", 0, 1);

    // simultaneous arrival
    drive(0, 13'd0, 0, 13'd0); step(2);
    drive(1, 13'h1F, 1, 13'h1F); step(2);
    expect_out("R3 tie goes to right busy", 1, 0);

    // R4: write mix does not change outcome
    l_wr_req = 1; r_wr_req = 0;
    drive(0, 13'd0, 0, 13'd0); step(2);
    drive(1, 13'h1F, 1, 13'h1F); step(2);
    expect_out("R4 tie with left writer", 1, 0);
    l_wr_req = 0; r_wr_req = 0;
    drive(0, 13'd0, 0, 13'd0); step(2);
    drive(1, 13'h1F, 1, 13'h1F); step(2);
    expect_out("R4 tie with two readers", 1, 0);
    l_wr_req = 0; r_wr_req = 1;
    drive(0, 13'd0, 0, 13'd0); step(2);
    drive(0, 13'd0, 1, 13'd3); step(2);
    drive(1, 13'd3, 1, 13'd3); step(2);
    expect_out("R4 left reader newcomer still busy", 0, 1);

    // boundary addresses
    l_wr_req = 1; r_wr_req = 1;
    drive(0, 13'd0, 0, 13'd0); step(2);
    drive(1, TOP, 1, TOP); step(2);
    expect_out("R3 tie at top address", 1, 0);
    drive(1, TOP, 1, TOP - 13'd1); step(2);
    expect_out("R1 top vs top-1 differ", 1, 1);
    drive(1, 13'd0, 1, 13'd0); step(2);
    expect_out("R3 tie at address zero", 1, 0);

    // slave mode with a live collision
    master_mode = 0; #1;
    expect_out("R7 slave outputs high", 1, 1);
    l_busy_in = 0; r_busy_in = 1; #1;
    expect_out("R7 left inhibited by pin", 1, 1);
    l_busy_in = 1; r_busy_in = 0; #1;
    expect_out("R7 right inhibited by pin", 1, 1);
    l_busy_in = 1; r_busy_in = 1; #1;
    expect_out("R7 pins high pass writes", 1, 1);
    drive(1, 13'd2, 0, 13'd2); step(2);
    l_busy_in = 0; #1;
    expect_out("R7 inhibit without collision", 1, 1);

    wait (sb.size() == 0);
    #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule